// File: doc/BRIEF.md
# Shift-Register Clock Divider

This block produces a single-cycle strobe once every N clock cycles, where N need not be a power of two. A 4-bit shift register with XNOR feedback steps through a fixed sequence of codes, and it serves as the cycle counter in place of an incrementer. When the register holds a chosen terminal code, the next edge reloads a chosen initial code and raises the strobe for one cycle. The code pair therefore sets the ratio. The default pair gives a ratio of 13.

The ratio is fixed when the block is built. It is set by three parameters: the initial code, the terminal code and a tap mask. Only one feedback gate sits between neighbouring register bits, so the next-state logic stays shallow for any ratio. The strobe can feed any logic that needs a slower periodic enable.

Top module: `lfsr_divider`

## Requirements
- R1: Reset is asynchronous and active high. While `rst` is high, the state register holds the initial code and `pulseOut` is low, without waiting for a clock edge.
- R2: A clock edge on which the state is not the terminal code shifts the register. Bit 0 takes the top bit. Each bit i ≥ 1 takes bit i-1 XNOR the top bit when mask bit i is 1, and takes bit i-1 unchanged otherwise. Bit 0 of the mask is ignored.
- R3: A clock edge on which the state equals the terminal code loads the initial code and sets `pulseOut` high for the cycle that follows. On every other edge `pulseOut` goes low.
- R4: Let P be the number of states from the initial code to the terminal code, counting both ends. Counting the first edge after reset release as edge 1, `pulseOut` is high after edge n exactly when n > 0 and n is a multiple of P. With the defaults (initial 0000, terminal 0101, mask 0010), P is 13.
- R5: When the initial and terminal codes differ, each high phase of `pulseOut` lasts exactly one cycle.
- R6: The all-ones code is the lockup state of the XNOR feedback, and the state register never holds it for a valid configuration.
- R7: When the initial and terminal codes are equal, `pulseOut` stays high on every cycle after the first edge following reset.
- R8: If reset is asserted while the state holds the terminal code, the pending strobe is lost. After release, the first strobe comes P edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| pulseOut | output | 1 | Divided strobe, high for one cycle per period |

## Verification
Reset and the terminal-code reload can fall on the same clock edge. The bench provokes this by watching its own edge count. When that count shows the default instance sitting at its terminal code, the bench raises reset just before the edge on which the strobe is due. It then judges that the strobe never appears and that the next strobe arrives a full period after release. A second case pulls reset in the middle of a high strobe on the equal-code instance, and the output must drop at once, before any edge.

// File: rtl/lfsrdiv_pkg.sv
package lfsrdiv_pkg;

  // Per-cycle command from the control to the state register
  typedef struct packed {
    logic load;   // reload the initial code
    logic shift;  // advance the shift register by one step
  } strobe_t;

endpackage

// File: rtl/lfsrdiv_datapath.sv
module lfsrdiv_datapath
  import lfsrdiv_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] START_STATE = '0,
  parameter logic [WIDTH-1:0] END_STATE = '0,
  parameter logic [WIDTH-1:0] TAP_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobe,
  output logic [WIDTH-1:0] count
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] shifted;

  // Bit 0 is fed straight from the top bit
  assign shifted[0] = count[TOP];

  // Bits 1..TOP: one XNOR when the tap is present, a plain wire otherwise
  for (genvar i = 1; i < WIDTH; i++) begin : g_bit
    if (TAP_MASK[i]) begin : g_tap
      assign shifted[i] = ~(count[i-1] ^ count[TOP]);
    end else begin : g_wire
      assign shifted[i] = count[i-1];
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      count <= START_STATE;
    end else if (strobe.load) begin
      count <= START_STATE;
    end else if (strobe.shift) begin
      count <= shifted;
    end
  end

  // R6
  no_lockup_chk: assert property (@(posedge clk) disable iff (rst)
    count != {WIDTH{1'b1}});

  if (START_STATE != END_STATE) begin : g_seq_chk
    // R2
    no_early_reload_chk: assert property (@(posedge clk) disable iff (rst)
      (count != END_STATE) |=> (count != START_STATE));
  end

endmodule

// File: rtl/lfsrdiv_control.sv
module lfsrdiv_control
  import lfsrdiv_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] START_STATE = '0,
  parameter logic [WIDTH-1:0] END_STATE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] count,
  output strobe_t          strobe,
  output logic             pulse
);

  logic atEnd;

  assign atEnd        = (count == END_STATE);
  assign strobe.load  = atEnd;
  assign strobe.shift = !atEnd;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pulse <= 1'b0;
    end else begin
      pulse <= atEnd;
    end
  end

  if (START_STATE != END_STATE) begin : g_width_chk
    // R5
    single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      pulse |=> !pulse);
  end

endmodule

// File: rtl/lfsr_divider.sv
module lfsr_divider
  import lfsrdiv_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] START_STATE = 4'b0000,
  parameter logic [WIDTH-1:0] END_STATE = 4'b0101,
  parameter logic [WIDTH-1:0] TAP_MASK = 4'b0010
) (
  input  logic clk,
  input  logic rst,
  output logic pulseOut
);

  strobe_t          strobe;
  logic [WIDTH-1:0] count;

  lfsrdiv_control #(
    .WIDTH(WIDTH), .START_STATE(START_STATE), .END_STATE(END_STATE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .count(count), .strobe(strobe), .pulse(pulseOut)
  );

  lfsrdiv_datapath #(
    .WIDTH(WIDTH), .START_STATE(START_STATE), .END_STATE(END_STATE),
    .TAP_MASK(TAP_MASK)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .count(count)
  );

  // R3
  reload_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (count == END_STATE) |=> (pulseOut && count == START_STATE));

  // R3
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (count != END_STATE) |=> !pulseOut);

endmodule

// File: tb/sim_lfsr_divider.sv
module sim_lfsr_divider;

  localparam int CLK_PERIOD = 10;
  localparam int NINST = 4;
  localparam logic [15:0] TAPS   = 16'h2222;
  localparam logic [15:0] STARTS = {4'b1110, 4'b0110, 4'b0000, 4'b0000};
  localparam logic [15:0] ENDS   = {4'b0011, 4'b0110, 4'b0001, 4'b0101};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NINST-1:0] pulse;
  int errors = 0;
  int checks = 0;
  int edgesSinceRelease = 0;
  int period [NINST];
  bit running = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < NINST; g++) begin : g_inst
    if (g == 0) begin : g_main
      lfsr_divider #(
        .WIDTH(4), .START_STATE(STARTS[g*4 +: 4]), .END_STATE(ENDS[g*4 +: 4]),
        .TAP_MASK(TAPS[g*4 +: 4])
      ) u0 (.clk(clk), .rst(rst), .pulseOut(pulse[g]));
    end else begin : g_alt
      lfsr_divider #(
        .WIDTH(4), .START_STATE(STARTS[g*4 +: 4]), .END_STATE(ENDS[g*4 +: 4]),
        .TAP_MASK(TAPS[g*4 +: 4])
      ) u_alt (.clk(clk), .rst(rst), .pulseOut(pulse[g]));
    end
  end

  // Next-state rule from R2
  function automatic logic [3:0] stepOnce(input logic [3:0] c, input logic [3:0] t);
    logic [3:0] n;
    n[0] = c[3];
    for (int i = 1; i < 4; i++) n[i] = t[i] ? ~(c[i-1] ^ c[3]) : c[i-1];
    return n;
  endfunction

  // State count from the initial to the terminal code, both included (R4)
  function automatic int statesInLoop(input logic [3:0] s, input logic [3:0] e,
                                      input logic [3:0] t);
    logic [3:0] c;
    int k;
    c = s;
    k = 1;
    while (c != e && k < 64) begin
      c = stepOnce(c, t);
      k++;
    end
    return k;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or posedge rst) begin
    if (rst) edgesSinceRelease <= 0;
    else edgesSinceRelease <= edgesSinceRelease + 1;
  end

  // Per-cycle comparison of every instance against R4/R7 (and R1 under reset)
  always @(negedge clk) begin
    if (running) begin
      for (int g = 0; g < NINST; g++) begin
        bit exp;
        if (rst) begin
          check(pulse[g] == 1'b0, "R1 output low in reset", pulse[g], 0);
        end else begin
          exp = (edgesSinceRelease > 0) && (edgesSinceRelease % period[g] == 0);
          // R2 R3 R4 R5 R6 R7: strobe pattern from the shift rule and reload
          check(pulse[g] == exp, $sformatf("R4 inst%0d n=%0d", g, edgesSinceRelease),
                pulse[g], exp);
        end
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int g = 0; g < NINST; g++)
      period[g] = statesInLoop(STARTS[g*4 +: 4], ENDS[g*4 +: 4], TAPS[g*4 +: 4]);
    check(period[0] == 13, "R4 default ratio", period[0], 13);
    check(period[2] == 1, "R7 equal codes", period[2], 1);

    running = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    // Many periods of every instance
    repeat (13 * 15) @(posedge clk);

    // R8: reset lands on the edge where u0 would strobe
    while (!(edgesSinceRelease % 13 == 12)) @(negedge clk);
    #1 rst = 1'b1;
    @(posedge clk);
    #1 check(pulse[0] == 1'b0, "R8 strobe suppressed", pulse[0], 0);
    #1 rst = 1'b0;
    repeat (13 * 4) @(posedge clk);

    // R1: asynchronous reset in the middle of a high strobe
    @(posedge clk);
    #1 check(pulse[2] == 1'b1, "R7 high before reset", pulse[2], 1);
    rst = 1'b1;
    #1 check(pulse == '0, "R1 asynchronous clear", pulse, 0);
    @(posedge clk);
    #2 rst = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    finishRun();
  end

endmodule